// File: doc/BRIEF.md
# DMA Channel Address Generator

This block is the address engine of a single DMA channel. It produces the source and destination word addresses for a transfer. A transfer is made of bursts, and a burst is made of words. Software first writes a set of shadow registers through a narrow write port. These hold the begin and current addresses, the burst and transfer sizes, the steps and the wrap settings for each side. A run command copies the shadow registers into the working registers. From then on, each trigger pulse moves one burst.

Each word takes two cycles on the request port. The first is a read at the source address and the second is a write at the destination address. Both addresses follow three nested rules: a signed step between words, a signed step between bursts, and a wrap back to a moving begin address after a set number of bursts. A wrap takes the place of the between-burst step.

The channel can run a whole transfer from a single trigger, and it can re-arm itself after each transfer. It raises a channel interrupt at the start or at the end of a transfer. A trigger that arrives while an earlier one is still pending sets an overflow flag.

Top module: `dmach_addr_gen`

## Requirements
- R1: After rst_n low, or one cycle after a ctl_hard_reset pulse, running, bus_req, trig_pending, ovf_flag, ch_irq and ovf_irq are all 0.
- R2: A ctl_run pulse while idle sets running and copies every shadow value into the working registers. Shadow writes made later do not change the transfer already started.
- R3: A trig pulse while running is 0 is ignored: trig_pending stays 0 and no request is issued.
- R4: Each burst is burst-size-field+1 words. A word is one cycle with bus_req=1, bus_we=0 at the source address, then one cycle with bus_req=1, bus_we=1 at the destination address. Between words of a burst, each address adds its own signed word step. The first read comes two cycles after the cycle in which trig is high.
- R5: At a burst boundary without a wrap, each address adds its own signed burst step to the address of the last word.
- R6: Each side has a wrap field equal to the number of bursts between wraps minus one. When the wrap counter is 0 at a burst boundary, the begin address adds the signed wrap step, the address becomes that new begin address, the counter reloads, and the burst step is not applied.
- R7: The transfer size field is the number of bursts minus one. Without continuous mode, running is 0 in the cycle after the last write.
- R8: In continuous mode, the working registers reload from the shadow registers at the end of a transfer, and running stays 1.
- R9: In one-shot mode, a single trigger runs every burst of the transfer, and each burst's first read directly follows the previous burst's last write.
- R10: With mode_irq_en=1, ch_irq pulses for one cycle. When mode_irq_at_start=1, the pulse is in the first read cycle of a transfer. Otherwise it is in the cycle after the last write. With mode_irq_en=0 it stays 0.
- R11: A trig that arrives while trig_pending is 1 and is not being consumed in that cycle sets ovf_flag. If mode_ovf_irq_en=1, ovf_irq pulses in the same cycle. ctl_clr_err clears ovf_flag and ctl_clr_trig clears trig_pending.
- R12: The shadow select codes on cfg_wr_sel are as follows. Source begin is 0 and source current is 1. Destination begin is 2 and destination current is 3. Burst size is 4 and transfer size is 5. Word step is 6 for the source and 7 for the destination. Burst step is 8 for the source and 9 for the destination. Source wrap size is 10 and source wrap step is 11. Destination wrap size is 12 and destination wrap step is 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Shadow register write strobe |
| cfg_wr_sel | input | 4 | Shadow register select code |
| cfg_wr_data | input | AW | Shadow write data; sizes use the low CW bits |
| ctl_run | input | 1 | Start the channel from the shadow values |
| ctl_hard_reset | input | 1 | Return the channel to idle |
| ctl_clr_trig | input | 1 | Clear the pending trigger |
| ctl_clr_err | input | 1 | Clear the overflow flag |
| mode_oneshot | input | 1 | One trigger runs the whole transfer |
| mode_cont | input | 1 | Re-arm after each transfer |
| mode_irq_at_start | input | 1 | Interrupt at transfer start (1) or end (0) |
| mode_irq_en | input | 1 | Channel interrupt enable |
| mode_ovf_irq_en | input | 1 | Overflow interrupt enable |
| trig | input | 1 | Burst trigger pulse |
| bus_req | output | 1 | Word request valid |
| bus_we | output | 1 | 0 read at source, 1 write at destination |
| bus_addr | output | AW | Request address |
| running | output | 1 | Channel is active |
| trig_pending | output | 1 | A trigger waits to be served |
| ovf_flag | output | 1 | Trigger overflow seen |
| ch_irq | output | 1 | Channel interrupt pulse |
| ovf_irq | output | 1 | Overflow interrupt pulse |

## Verification
The bench builds the block with AW=16 and CW=8.

Sixteen-bit addresses let negative steps wrap modulo 2^16, so signed arithmetic is visible on the port. The scenarios use steps of 0xFFFF and 0xFFF8.

Eight-bit counters permit a wrap field of 0xFF. That value keeps wrapping out of the plain stepping scenarios. Small wrap fields of 0, 1 and 2 make wraps fall on every burst, or on every second or third burst, within a few cycles.

// File: rtl/dmach_pkg.sv
// Shared types and shadow select codes for the DMA channel address generator.
package dmach_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } seq_state_e;

    localparam int SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_SRC_BEG   = 4'd0;
    localparam logic [SEL_W-1:0] SEL_SRC_CUR   = 4'd1;
    localparam logic [SEL_W-1:0] SEL_DST_BEG   = 4'd2;
    localparam logic [SEL_W-1:0] SEL_DST_CUR   = 4'd3;
    localparam logic [SEL_W-1:0] SEL_BSIZE     = 4'd4;
    localparam logic [SEL_W-1:0] SEL_XSIZE     = 4'd5;
    localparam logic [SEL_W-1:0] SEL_SRC_WSTEP = 4'd6;
    localparam logic [SEL_W-1:0] SEL_DST_WSTEP = 4'd7;
    localparam logic [SEL_W-1:0] SEL_SRC_BSTEP = 4'd8;
    localparam logic [SEL_W-1:0] SEL_DST_BSTEP = 4'd9;
    localparam logic [SEL_W-1:0] SEL_SRC_WRSZ  = 4'd10;
    localparam logic [SEL_W-1:0] SEL_SRC_WRST  = 4'd11;
    localparam logic [SEL_W-1:0] SEL_DST_WRSZ  = 4'd12;
    localparam logic [SEL_W-1:0] SEL_DST_WRST  = 4'd13;

endpackage

// File: rtl/dmach_shadow.sv
// Shadow register file: holds software-written channel settings until a run
// or a continuous reload copies them into the working registers.
// Assumes AW >= CW; size fields take the low CW bits of the write data.
// Side index 0 is the source, 1 the destination.
module dmach_shadow
    import dmach_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [AW-1:0]    wr_data,
    output logic [AW-1:0]    sh_beg   [2],
    output logic [AW-1:0]    sh_cur   [2],
    output logic [AW-1:0]    sh_wstep [2],
    output logic [AW-1:0]    sh_bstep [2],
    output logic [AW-1:0]    sh_wrst  [2],
    output logic [CW-1:0]    sh_wrsz  [2],
    output logic [CW-1:0]    sh_bsize,
    output logic [CW-1:0]    sh_xsize
);

    genvar s;
    generate
        for (s = 0; s < 2; s++) begin : g_side
            localparam logic [SEL_W-1:0] C_BEG   = (s == 0) ? SEL_SRC_BEG   : SEL_DST_BEG;
            localparam logic [SEL_W-1:0] C_CUR   = (s == 0) ? SEL_SRC_CUR   : SEL_DST_CUR;
            localparam logic [SEL_W-1:0] C_WSTEP = (s == 0) ? SEL_SRC_WSTEP : SEL_DST_WSTEP;
            localparam logic [SEL_W-1:0] C_BSTEP = (s == 0) ? SEL_SRC_BSTEP : SEL_DST_BSTEP;
            localparam logic [SEL_W-1:0] C_WRSZ  = (s == 0) ? SEL_SRC_WRSZ  : SEL_DST_WRSZ;
            localparam logic [SEL_W-1:0] C_WRST  = (s == 0) ? SEL_SRC_WRST  : SEL_DST_WRST;

            // Capture writes addressed to this side's fields.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_beg[s]   <= '0;
                    sh_cur[s]   <= '0;
                    sh_wstep[s] <= '0;
                    sh_bstep[s] <= '0;
                    sh_wrst[s]  <= '0;
                    sh_wrsz[s]  <= '0;
                end else if (wr_en) begin
                    if (wr_sel == C_BEG)   sh_beg[s]   <= wr_data;
                    if (wr_sel == C_CUR)   sh_cur[s]   <= wr_data;
                    if (wr_sel == C_WSTEP) sh_wstep[s] <= wr_data;
                    if (wr_sel == C_BSTEP) sh_bstep[s] <= wr_data;
                    if (wr_sel == C_WRST)  sh_wrst[s]  <= wr_data;
                    if (wr_sel == C_WRSZ)  sh_wrsz[s]  <= wr_data[CW-1:0];
                end
            end
        end
    endgenerate

    // Capture writes to the shared size fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_bsize <= '0;
            sh_xsize <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_BSIZE) sh_bsize <= wr_data[CW-1:0];
            if (wr_sel == SEL_XSIZE) sh_xsize <= wr_data[CW-1:0];
        end
    end

endmodule

// File: rtl/dmach_side.sv
// Address walker for one side of the channel. It steps inside a burst, steps
// or wraps at burst boundaries, and reloads from the shadow registers on load.
// Assumes word_step and burst_end are never high together; load wins over both.
module dmach_side #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic          word_step,
    input  logic          burst_end,
    input  logic [AW-1:0] sh_beg,
    input  logic [AW-1:0] sh_cur,
    input  logic [AW-1:0] sh_wstep,
    input  logic [AW-1:0] sh_bstep,
    input  logic [AW-1:0] sh_wrst,
    input  logic [CW-1:0] sh_wrsz,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_q, beg_q, wstep_q, bstep_q, wrst_q;
    logic [CW-1:0] wrsz_q, wcnt_q;
    logic [AW-1:0] beg_wrapped;

    assign beg_wrapped = beg_q + wrst_q;
    assign addr        = addr_q;

    // Working address, begin address and wrap counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr_q  <= '0;
            beg_q   <= '0;
            wstep_q <= '0;
            bstep_q <= '0;
            wrst_q  <= '0;
            wrsz_q  <= '0;
            wcnt_q  <= '0;
        end else if (load) begin
            addr_q  <= sh_cur;
            beg_q   <= sh_beg;
            wstep_q <= sh_wstep;
            bstep_q <= sh_bstep;
            wrst_q  <= sh_wrst;
            wrsz_q  <= sh_wrsz;
            wcnt_q  <= sh_wrsz;
        end else if (burst_end) begin
            if (wcnt_q == '0) begin
                beg_q  <= beg_wrapped;
                addr_q <= beg_wrapped;
                wcnt_q <= wrsz_q;
            end else begin
                addr_q <= addr_q + bstep_q;
                wcnt_q <= wcnt_q - 1'b1;
            end
        end else if (word_step) begin
            addr_q <= addr_q + wstep_q;
        end
    end

    // R6: the wrap counter never exceeds the loaded wrap field.
    p_wrap_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= wrsz_q);

    // R6: right after a wrap, the address sits on the new begin address.
    p_wrap_lands_on_begin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_end && !load && !clr && wcnt_q == '0) |=> (addr_q == beg_q));

endmodule

// File: rtl/dmach_seq.sv
// Channel sequencer: run and stop, burst and word counting, trigger pending
// and overflow flags, and interrupt pulses. Drives the request strobes and
// tells the address walkers when to load, step and close a burst.
// Assumes trig is a level sampled each cycle; a held trig counts once per cycle.
module dmach_seq
    import dmach_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hard_rst,
    input  logic          run,
    input  logic          trig,
    input  logic          clr_trig,
    input  logic          clr_err,
    input  logic          mode_oneshot,
    input  logic          mode_cont,
    input  logic          mode_irq_at_start,
    input  logic          mode_irq_en,
    input  logic          mode_ovf_irq_en,
    input  logic [CW-1:0] sh_bsize,
    input  logic [CW-1:0] sh_xsize,
    output logic          load,
    output logic          word_step,
    output logic          burst_end,
    output logic          bus_req,
    output logic          bus_we,
    output logic          running,
    output logic          trig_pending,
    output logic          ovf_flag,
    output logic          ch_irq,
    output logic          ovf_irq
);

    seq_state_e    st;
    logic [CW-1:0] bsize_q, wcnt_q, bleft_q;
    logic          first_q, pend_q, ovf_q, irq_q, ovf_irq_q;
    logic          start_run, begin_burst, last_word, last_burst;
    logic          cont_reload, ovf_set, irq_event, pend_next;

    // Decode of the events in the current cycle.
    always_comb begin
        start_run   = run && (st == ST_IDLE);
        begin_burst = (st == ST_WAIT) && pend_q;
        last_word   = (st == ST_WR) && (wcnt_q == '0);
        last_burst  = last_word && (bleft_q == '0);
        cont_reload = last_burst && mode_cont;
        ovf_set     = trig && (st != ST_IDLE) && pend_q && !begin_burst;
        irq_event   = mode_irq_at_start ? (begin_burst && first_q) : last_burst;
    end

    // Next value of the pending-trigger flag.
    always_comb begin
        pend_next = pend_q;
        if (begin_burst)                   pend_next = 1'b0;
        if (trig && (st != ST_IDLE))       pend_next = 1'b1;
        if (clr_trig)                      pend_next = 1'b0;
        if (last_burst && !mode_cont)      pend_next = 1'b0;
    end

    assign load         = start_run || cont_reload;
    assign word_step    = (st == ST_WR) && (wcnt_q != '0);
    assign burst_end    = last_word;
    assign bus_req      = (st == ST_RD) || (st == ST_WR);
    assign bus_we       = (st == ST_WR);
    assign running      = (st != ST_IDLE);
    assign trig_pending = pend_q;
    assign ovf_flag     = ovf_q;
    assign ch_irq       = irq_q;
    assign ovf_irq      = ovf_irq_q;

    // State machine with the word and burst counters.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_rst) begin
            st      <= ST_IDLE;
            bsize_q <= '0;
            wcnt_q  <= '0;
            bleft_q <= '0;
            first_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (run) begin
                    st      <= ST_WAIT;
                    bsize_q <= sh_bsize;
                    bleft_q <= sh_xsize;
                    first_q <= 1'b1;
                end
                ST_WAIT: if (pend_q) begin
                    st      <= ST_RD;
                    wcnt_q  <= bsize_q;
                    first_q <= 1'b0;
                end
                ST_RD: st <= ST_WR;
                ST_WR: begin
                    if (wcnt_q != '0) begin
                        wcnt_q <= wcnt_q - 1'b1;
                        st     <= ST_RD;
                    end else if (bleft_q != '0) begin
                        bleft_q <= bleft_q - 1'b1;
                        if (mode_oneshot) begin
                            st     <= ST_RD;
                            wcnt_q <= bsize_q;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end else if (mode_cont) begin
                        st      <= ST_WAIT;
                        bsize_q <= sh_bsize;
                        bleft_q <= sh_xsize;
                        first_q <= 1'b1;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Pending, overflow and interrupt flags.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_rst) begin
            pend_q    <= 1'b0;
            ovf_q     <= 1'b0;
            irq_q     <= 1'b0;
            ovf_irq_q <= 1'b0;
        end else begin
            pend_q    <= pend_next;
            ovf_q     <= ovf_set ? 1'b1 : (clr_err ? 1'b0 : ovf_q);
            irq_q     <= mode_irq_en && irq_event;
            ovf_irq_q <= mode_ovf_irq_en && ovf_set;
        end
    end

    // R4: a write cycle always follows a read cycle.
    p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> $past(bus_req && !bus_we));

    // R3: an idle channel holds no pending trigger.
    p_idle_no_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !trig_pending);

    // R11: overflow only rises after a trigger.
    p_ovf_needs_trig_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(trig));

    // R7: the channel stops only after a write cycle or a hard reset.
    p_stop_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> ($past(st == ST_WR) || $past(hard_rst)));

    // R10: a channel interrupt needs the enable in the cycle before.
    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ch_irq |-> $past(mode_irq_en));

endmodule

// File: rtl/dmach_addr_gen.sv
// DMA channel address generator top. It wires the shadow register file, the
// sequencer and one address walker per side, and muxes the request address.
// Assumes the request port accepts every cycle; reads use the source side and
// writes use the destination side.
module dmach_addr_gen
    import dmach_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_en,
    input  logic [3:0]    cfg_wr_sel,
    input  logic [AW-1:0] cfg_wr_data,
    input  logic          ctl_run,
    input  logic          ctl_hard_reset,
    input  logic          ctl_clr_trig,
    input  logic          ctl_clr_err,
    input  logic          mode_oneshot,
    input  logic          mode_cont,
    input  logic          mode_irq_at_start,
    input  logic          mode_irq_en,
    input  logic          mode_ovf_irq_en,
    input  logic          trig,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic          running,
    output logic          trig_pending,
    output logic          ovf_flag,
    output logic          ch_irq,
    output logic          ovf_irq
);

    logic [AW-1:0] sh_beg   [2];
    logic [AW-1:0] sh_cur   [2];
    logic [AW-1:0] sh_wstep [2];
    logic [AW-1:0] sh_bstep [2];
    logic [AW-1:0] sh_wrst  [2];
    logic [CW-1:0] sh_wrsz  [2];
    logic [CW-1:0] sh_bsize, sh_xsize;
    logic [AW-1:0] side_addr [2];
    logic          load, word_step, burst_end;

    dmach_shadow #(.AW(AW), .CW(CW)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_sel),
        .wr_data  (cfg_wr_data),
        .sh_beg   (sh_beg),
        .sh_cur   (sh_cur),
        .sh_wstep (sh_wstep),
        .sh_bstep (sh_bstep),
        .sh_wrst  (sh_wrst),
        .sh_wrsz  (sh_wrsz),
        .sh_bsize (sh_bsize),
        .sh_xsize (sh_xsize)
    );

    dmach_seq #(.CW(CW)) u_seq (
        .clk               (clk),
        .rst_n             (rst_n),
        .hard_rst          (ctl_hard_reset),
        .run               (ctl_run),
        .trig              (trig),
        .clr_trig          (ctl_clr_trig),
        .clr_err           (ctl_clr_err),
        .mode_oneshot      (mode_oneshot),
        .mode_cont         (mode_cont),
        .mode_irq_at_start (mode_irq_at_start),
        .mode_irq_en       (mode_irq_en),
        .mode_ovf_irq_en   (mode_ovf_irq_en),
        .sh_bsize          (sh_bsize),
        .sh_xsize          (sh_xsize),
        .load              (load),
        .word_step         (word_step),
        .burst_end         (burst_end),
        .bus_req           (bus_req),
        .bus_we            (bus_we),
        .running           (running),
        .trig_pending      (trig_pending),
        .ovf_flag          (ovf_flag),
        .ch_irq            (ch_irq),
        .ovf_irq           (ovf_irq)
    );

    genvar s;
    generate
        for (s = 0; s < 2; s++) begin : g_walk
            dmach_side #(.AW(AW), .CW(CW)) u_side (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (ctl_hard_reset),
                .load      (load),
                .word_step (word_step),
                .burst_end (burst_end),
                .sh_beg    (sh_beg[s]),
                .sh_cur    (sh_cur[s]),
                .sh_wstep  (sh_wstep[s]),
                .sh_bstep  (sh_bstep[s]),
                .sh_wrst   (sh_wrst[s]),
                .sh_wrsz   (sh_wrsz[s]),
                .addr      (side_addr[s])
            );
        end
    endgenerate

    assign bus_addr = bus_we ? side_addr[1] : side_addr[0];

    // R1: no request while the channel is idle.
    p_no_req_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> running);

endmodule

// File: tb/dmach_addr_gen_bench.sv
module dmach_addr_gen_bench;

    localparam int AW = 16;
    localparam int CW = 8;

    typedef struct packed {
        logic [15:0] sbeg, dbeg, bsize, xsize;
        logic [15:0] sws, dws, sbs, dbs;
        logic [15:0] swz, swt, dwz, dwt, one;
    } scen_t;

    // Fields: src, dst, bsize, xsize, word steps, burst steps, wrap sz/step per side, oneshot
    localparam scen_t SCN [4] = '{
        '{16'h1000, 16'h2000, 16'd1, 16'd2, 16'h0001, 16'h0002, 16'h0004, 16'h0008,
          16'h00FF, 16'h0000, 16'h00FF, 16'h0000, 16'd0},
        '{16'h0100, 16'h0800, 16'd0, 16'd5, 16'h0000, 16'h0000, 16'h0001, 16'hFFFF,
          16'h0001, 16'h0010, 16'h0002, 16'hFFFC, 16'd1},
        '{16'h3000, 16'h3100, 16'd2, 16'd1, 16'hFFFF, 16'hFFFE, 16'hFFF0, 16'h0020,
          16'h00FF, 16'h0000, 16'h00FF, 16'h0000, 16'd0},
        '{16'h0040, 16'h0F00, 16'd1, 16'd3, 16'h0002, 16'h0001, 16'h0007, 16'h0007,
          16'h0000, 16'h0008, 16'h0000, 16'hFFF8, 16'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0;
    logic [3:0] cfg_wr_sel = '0;
    logic [AW-1:0] cfg_wr_data = '0;
    logic ctl_run = 1'b0, ctl_hard_reset = 1'b0, ctl_clr_trig = 1'b0, ctl_clr_err = 1'b0;
    logic mode_oneshot = 1'b0, mode_cont = 1'b0, mode_irq_at_start = 1'b0;
    logic mode_irq_en = 1'b0, mode_ovf_irq_en = 1'b0, trig = 1'b0;
    logic bus_req, bus_we, running, trig_pending, ovf_flag, ch_irq, ovf_irq;
    logic [AW-1:0] bus_addr;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dmach_addr_gen #(.AW(AW), .CW(CW)) u_dmach_addr_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .ctl_run(ctl_run), .ctl_hard_reset(ctl_hard_reset),
        .ctl_clr_trig(ctl_clr_trig), .ctl_clr_err(ctl_clr_err),
        .mode_oneshot(mode_oneshot), .mode_cont(mode_cont),
        .mode_irq_at_start(mode_irq_at_start), .mode_irq_en(mode_irq_en),
        .mode_ovf_irq_en(mode_ovf_irq_en), .trig(trig), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .running(running),
        .trig_pending(trig_pending), .ovf_flag(ovf_flag), .ch_irq(ch_irq),
        .ovf_irq(ovf_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [15:0] data);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel[3:0]; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic do_run();       ctl_run = 1'b1;        @(negedge clk); ctl_run = 1'b0;        endtask
    task automatic do_trig();      trig = 1'b1;           @(negedge clk); trig = 1'b0;           endtask
    task automatic do_hard();      ctl_hard_reset = 1'b1; @(negedge clk); ctl_hard_reset = 1'b0; endtask

    task automatic simple_cfg(input logic [15:0] sa, input logic [15:0] da,
                              input logic [15:0] bs, input logic [15:0] xs);
        wr(0, sa); wr(1, sa); wr(2, da); wr(3, da); wr(4, bs); wr(5, xs);
        wr(6, 0); wr(7, 0); wr(8, 0); wr(9, 0);
        wr(10, 16'h00FF); wr(11, 0); wr(12, 16'h00FF); wr(13, 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset flags", {running, bus_req, trig_pending, ovf_flag, ch_irq, ovf_irq}, 0);

        // R3 trigger while idle is ignored
        do_trig();
        chk("R3 idle trig pending", trig_pending, 0);
        @(negedge clk);
        chk("R3 idle trig no request", bus_req, 0);

        // Table walk: R4 R5 R6 R7 R9 R12
        for (int i = 0; i < 4; i++) begin
            scen_t c;
            logic [15:0] sa, sb, da, db;
            int swc, dwc;
            c = SCN[i];
            wr(0, c.sbeg); wr(1, c.sbeg); wr(2, c.dbeg); wr(3, c.dbeg);
            wr(4, c.bsize); wr(5, c.xsize);
            wr(6, c.sws); wr(7, c.dws); wr(8, c.sbs); wr(9, c.dbs);
            wr(10, c.swz); wr(11, c.swt); wr(12, c.dwz); wr(13, c.dwt);
            mode_oneshot = c.one[0]; mode_cont = 1'b0;
            do_run();
            sa = c.sbeg; sb = c.sbeg; da = c.dbeg; db = c.dbeg;
            swc = int'(c.swz); dwc = int'(c.dwz);
            for (int b = 0; b <= int'(c.xsize); b++) begin
                if (c.one[0] && b > 0) begin
                    chk($sformatf("R9 back-to-back s%0d b%0d", i, b), bus_req, 1);
                end else begin
                    if (!c.one[0] || b == 0) do_trig();
                    for (int k = 0; k < 20 && !bus_req; k++) @(negedge clk);
                end
                for (int w = 0; w <= int'(c.bsize); w++) begin
                    chk($sformatf("R4 R5 R6 R12 read s%0d b%0d w%0d", i, b, w),
                        {bus_req, bus_we, bus_addr}, {2'b10, sa});
                    @(negedge clk);
                    chk($sformatf("R4 R5 R6 R12 write s%0d b%0d w%0d", i, b, w),
                        {bus_req, bus_we, bus_addr}, {2'b11, da});
                    @(negedge clk);
                    if (w < int'(c.bsize)) begin
                        sa = sa + c.sws; da = da + c.dws;
                    end
                end
                if (swc == 0) begin sb = sb + c.swt; sa = sb; swc = int'(c.swz); end
                else begin sa = sa + c.sbs; swc--; end
                if (dwc == 0) begin db = db + c.dwt; da = db; dwc = int'(c.dwz); end
                else begin da = da + c.dbs; dwc--; end
            end
            chk($sformatf("R7 stopped s%0d", i), {running, bus_req}, 0);
        end

        // R2 and R10 start-of-transfer interrupt
        mode_oneshot = 1'b0; mode_cont = 1'b0;
        simple_cfg(16'h0500, 16'h0600, 0, 0);
        mode_irq_en = 1'b1; mode_irq_at_start = 1'b1;
        do_run();
        wr(1, 16'h0777);
        do_trig();
        @(negedge clk);
        chk("R2 shadow write after run ignored", {bus_req, bus_we, bus_addr}, {2'b10, 16'h0500});
        chk("R10 start irq in first read", ch_irq, 1);
        @(negedge clk);
        chk("R10 start irq one cycle", ch_irq, 0);
        @(negedge clk);
        chk("R7 single-burst stop", running, 0);

        // R10 end-of-transfer interrupt
        mode_irq_at_start = 1'b0;
        do_run();
        do_trig();
        @(negedge clk);
        chk("R2 new shadow used", bus_addr, 16'h0777);
        chk("R10 no irq at start in end mode", ch_irq, 0);
        @(negedge clk);
        @(negedge clk);
        chk("R10 end irq after last write", {ch_irq, running}, 2'b10);

        // R10 disabled interrupt stays low
        mode_irq_en = 1'b0;
        begin
            logic seen;
            seen = 1'b0;
            do_run();
            do_trig();
            for (int k = 0; k < 5; k++) begin seen |= ch_irq; @(negedge clk); end
            chk("R10 irq disabled", seen, 0);
        end

        // R8 continuous reload
        mode_cont = 1'b1;
        wr(8, 16'h0005);
        do_run();
        do_trig();
        @(negedge clk);
        chk("R8 first transfer read", bus_addr, 16'h0777);
        @(negedge clk);
        @(negedge clk);
        chk("R8 still running", running, 1);
        do_trig();
        @(negedge clk);
        chk("R8 reloaded address", {bus_req, bus_addr}, {1'b1, 16'h0777});
        do_hard();
        chk("R1 hard reset stops", {running, bus_req, trig_pending}, 0);

        // R11 overflow
        mode_cont = 1'b0; mode_ovf_irq_en = 1'b1;
        wr(4, 16'd7);
        do_run();
        trig = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        trig = 1'b0;
        chk("R11 overflow flag and irq", {ovf_flag, ovf_irq}, 2'b11);
        @(negedge clk);
        chk("R11 ovf irq pulse", {ovf_flag, ovf_irq, trig_pending}, 3'b101);
        ctl_clr_err = 1'b1; @(negedge clk); ctl_clr_err = 1'b0;
        chk("R11 clear error", ovf_flag, 0);
        ctl_clr_trig = 1'b1; @(negedge clk); ctl_clr_trig = 1'b0;
        chk("R11 clear trigger", {trig_pending, running}, 2'b01);
        do_hard();
        chk("R1 hard reset mid burst",
            {running, bus_req, trig_pending, ovf_flag, ch_irq, ovf_irq}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule